// File: doc/BRIEF.md
# Transmit clock presence monitor

This block decides whether the transmit-side clock feeding the line drivers is actually running. It watches one of two candidate clocks: the plain transmit clock, or the smoothed clock that comes out of the jitter attenuator when the attenuator sits in the transmit path. It judges that clock against a reference clock from a free-running oscillator, which is present at all times, so the monitor never stalls, even with no line input and no external reference.

Each edge of the monitored clock flips a toggle register in that clock's own domain. A two-flop synchronizer brings the toggle into the reference domain, where any change of the synchronized value counts as one period. A counter issues a check strobe once every `WINDOW` reference cycles (10 by default). At each strobe the block sets the loss flag if the window held no period and clears it if the window held at least one. While the flag is set, the block asks for both line drivers to be put in high impedance. Changing the attenuator placement mode changes which clock is watched. It also discards what the current window has seen, so one decision never mixes two clocks.

Top module: `txclk_presence_mon`

## Requirements
- R1: A check strobe occurs once every `WINDOW` reference cycles. After reset is released, the first strobe falls on the `WINDOW`-th rising reference edge, so the flag cannot change before that edge.
- R2: At a strobe, if at least one rising edge of the monitored clock was seen since the previous strobe, `los_o` becomes 0.
- R3: At a strobe, if no rising edge of the monitored clock was seen since the previous strobe, `los_o` becomes 1.
- R4: With `atten_mode` = 2'b01 the smoothing clock is monitored. With 2'b00, 2'b10 or 2'b11 the transmit clock is monitored. The clock that is not selected has no effect on `los_o`.
- R5: `drv_hiz_o` is 1 exactly when `los_o` is 1.
- R6: `los_o` changes only at strobes. A single isolated edge of the monitored clock, with the flag otherwise set, clears the flag for exactly `WINDOW` reference cycles.
- R7: While `rst_n` is 0, `los_o` and `drv_hiz_o` are 0.
- R8: A change of `atten_mode` that switches the monitored clock clears the window's activity record. If the newly selected clock is stopped, the flag is 1 after the first strobe that follows the change, which comes within `WINDOW` reference cycles.
- R9: After the monitored clock stops or starts, `los_o` takes its new value within 2*`WINDOW`+3 reference cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Always-running reference clock from the free-running oscillator |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_clk | input | 1 | Transmit clock, one candidate for monitoring |
| smooth_clk | input | 1 | Attenuator smoothing clock, the other candidate |
| atten_mode | input | 2 | Attenuator placement; 2'b01 means in the transmit path |
| los_o | output | 1 | Output loss-of-signal flag, 1 = monitored clock absent |
| drv_hiz_o | output | 1 | Request to put both line drivers in high impedance |

## Verification
A corrupted activity record would show at the ports on the next strobe, within `WINDOW` reference cycles, as a flag that is set while the clock runs or that stays clear after the clock stops. A strobe counter with the wrong period would move the moment the flag first changes after reset, and would alter how long an isolated edge keeps the flag clear. A wrong source select, or a record that a mode switch fails to clear, would make the flag follow the unselected clock or lag one window behind after the switch.

// File: rtl/txmon_pkg.sv
package txmon_pkg;
  typedef logic [1:0] place_t;
  localparam place_t PLACE_IN_TX_PATH = 2'b01;

  function automatic logic watch_smooth(input place_t mode);
    return mode == PLACE_IN_TX_PATH;
  endfunction
endpackage

// File: rtl/txmon_toggle.sv
module txmon_toggle (
  input  logic mon_clk,
  input  logic rst_n,
  output logic tog_o
);
  always_ff @(posedge mon_clk or negedge rst_n) begin
    if (!rst_n) tog_o <= 1'b0;
    else        tog_o <= ~tog_o;
  end
endmodule

// File: rtl/txmon_sync.sv
module txmon_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '0;
    else        chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/txmon_strobe.sv
module txmon_strobe #(
  parameter int WINDOW = 10
) (
  input  logic clk,
  input  logic rst_n,
  output logic strobe_o
);
  localparam int CW = (WINDOW > 1) ? $clog2(WINDOW) : 1;
  localparam logic [CW-1:0] LAST = CW'(WINDOW - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (cnt == LAST) cnt <= '0;
    else                 cnt <= cnt + 1'b1;
  end

  assign strobe_o = (cnt == LAST);

  // independent gap counter guarding the strobe period
  logic [15:0] gap;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        gap <= '0;
    else if (strobe_o) gap <= '0;
    else               gap <= gap + 1'b1;
  end

  a_r1_strobe_period: assert property (@(posedge clk) disable iff (!rst_n)
    strobe_o |-> gap == 16'(WINDOW - 1));
endmodule

// File: rtl/txmon_activity.sv
module txmon_activity (
  input  logic clk,
  input  logic rst_n,
  input  logic use_smooth,
  input  logic tx_s,
  input  logic sm_s,
  input  logic strobe,
  output logic present_o,
  output logic switch_o
);
  logic sel_s, prev, use_q, seen, change;

  assign sel_s    = use_smooth ? sm_s : tx_s;
  assign switch_o = use_smooth != use_q;
  assign change   = (sel_s != prev) && !switch_o;
  assign present_o = seen | change;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev  <= 1'b0;
      use_q <= 1'b0;
      seen  <= 1'b0;
    end else begin
      prev  <= sel_s;
      use_q <= use_smooth;
      if (strobe || switch_o) seen <= 1'b0;
      else if (change)        seen <= 1'b1;
    end
  end

  // R8: a switch leaves no record of the old clock behind
  a_r8_switch_clears: assert property (@(posedge clk) disable iff (!rst_n)
    switch_o && !strobe |=> !seen);
endmodule

// File: rtl/txmon_decide.sv
module txmon_decide (
  input  logic clk,
  input  logic rst_n,
  input  logic strobe,
  input  logic present,
  input  logic switching,
  output logic los_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      los_o <= 1'b0;
    else if (strobe) los_o <= switching | ~present;
  end

  a_r2_present_clears: assert property (@(posedge clk) disable iff (!rst_n)
    strobe && present && !switching |=> !los_o);
  a_r3_absent_sets: assert property (@(posedge clk) disable iff (!rst_n)
    strobe && !present |=> los_o);
  a_r6_hold_between: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe |=> $stable(los_o));
endmodule

// File: rtl/txclk_presence_mon.sv
module txclk_presence_mon
  import txmon_pkg::*;
#(
  parameter int WINDOW      = 10,
  parameter int SYNC_STAGES = 2
) (
  input  logic       ref_clk,
  input  logic       rst_n,
  input  logic       tx_clk,
  input  logic       smooth_clk,
  input  logic [1:0] atten_mode,
  output logic       los_o,
  output logic       drv_hiz_o
);
  localparam int NSRC = 2;

  logic [NSRC-1:0] src_clk, tog, tog_s;
  logic strobe, present, switching, use_smooth;

  assign src_clk = {smooth_clk, tx_clk};

  for (genvar i = 0; i < NSRC; i++) begin : g_src
    txmon_toggle u_tog (.mon_clk(src_clk[i]), .rst_n(rst_n), .tog_o(tog[i]));
    txmon_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(ref_clk), .rst_n(rst_n), .d(tog[i]), .q(tog_s[i]));
  end

  assign use_smooth = watch_smooth(atten_mode);

  txmon_strobe #(.WINDOW(WINDOW)) u_strobe (
    .clk(ref_clk), .rst_n(rst_n), .strobe_o(strobe));

  txmon_activity u_act (
    .clk(ref_clk), .rst_n(rst_n), .use_smooth(use_smooth),
    .tx_s(tog_s[0]), .sm_s(tog_s[1]), .strobe(strobe),
    .present_o(present), .switch_o(switching));

  txmon_decide u_dec (
    .clk(ref_clk), .rst_n(rst_n), .strobe(strobe), .present(present),
    .switching(switching), .los_o(los_o));

  assign drv_hiz_o = los_o;

  a_r5_hiz_rises_with_flag: assert property (@(posedge ref_clk) disable iff (!rst_n)
    $rose(los_o) |-> drv_hiz_o);
endmodule

// File: tb/test_txclk_presence_mon.sv
module test_txclk_presence_mon;
  localparam int CLK_NS = 10;
  localparam int WIN    = 10;
  localparam int LAT    = 2*WIN + 3;

  logic ref_clk = 1'b0, rst_n = 1'b0, tx_clk = 1'b0, smooth_clk = 1'b0;
  logic [1:0] mode = 2'b00;
  logic los, hiz;
  bit tx_en = 0, sm_en = 0;
  int tx_kick = 0, sm_kick = 0;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  txclk_presence_mon #(.WINDOW(WIN)) i_txclk_presence_mon (
    .ref_clk(ref_clk), .rst_n(rst_n), .tx_clk(tx_clk), .smooth_clk(smooth_clk),
    .atten_mode(mode), .los_o(los), .drv_hiz_o(hiz));

  always #(CLK_NS/2) ref_clk = ~ref_clk;
  always begin
    #12;
    if (tx_en || tx_kick > 0) begin
      tx_clk = ~tx_clk;
      if (tx_kick > 0) tx_kick--;
    end
  end
  always begin
    #14;
    if (sm_en || sm_kick > 0) begin
      smooth_clk = ~smooth_clk;
      if (sm_kick > 0) sm_kick--;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge ref_clk);
  endtask

  task automatic watch(input int n, output int lows, output int changes);
    logic last;
    lows = 0; changes = 0; last = los;
    for (int i = 0; i < n; i++) begin
      @(negedge ref_clk);
      if (!los) lows++;
      if (los != last) changes++;
      last = los;
    end
  endtask

  task automatic until_val(input logic v, output int n);
    n = 0;
    while (los != v && n < 200) begin
      @(negedge ref_clk);
      n++;
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    #(CLK_NS * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

  initial begin
    int lows, ch, n;
    // R7 reset state
    cyc(3);
    check(los == 1'b0, "R7 los in reset", los, 0);
    check(hiz == 1'b0, "R7 hiz in reset", hiz, 0);
    rst_n = 1'b1;
    // R1: flag still 0 for WIN-1 cycles, set at the WIN-th edge (clocks stopped)
    watch(WIN - 1, lows, ch);
    check(lows == WIN - 1, "R1 no strobe before window end", lows, WIN - 1);
    cyc(1);
    check(los == 1'b1, "R1 first strobe sets flag", los, 1);

    // R2 R3 R4 R5 sweep over modes and clock states
    for (int m = 0; m < 4; m++)
      for (int t = 0; t < 2; t++)
        for (int s = 0; s < 2; s++) begin
          logic exp;
          mode = 2'(m); tx_en = bit'(t); sm_en = bit'(s);
          cyc(3 * WIN);
          exp = (m == 1) ? !s : !t;
          check(los == exp, exp ? "R3 absent sets flag" : "R2 present clears flag", los, exp);
          check(hiz == exp, "R5 hiz follows flag", hiz, exp);
          watch(WIN, lows, ch);
          check(ch == 0, "R4 unselected clock has no effect", ch, 0);
        end

    // R9 stop and start latency
    mode = 2'b00; tx_en = 1; sm_en = 0; cyc(3 * WIN);
    tx_en = 0; until_val(1'b1, n);
    check(n >= 1 && n <= LAT, "R9 stop detected", n, LAT);
    tx_en = 1; until_val(1'b0, n);
    check(n >= 1 && n <= LAT, "R9 start detected", n, LAT);

    // R8 switch to a stopped smoothing clock at several offsets
    for (int k = 0; k < WIN; k++) begin
      mode = 2'b00; tx_en = 1; sm_en = 0; cyc(3 * WIN + k);
      check(los == 1'b0, "R8 tx running before switch", los, 0);
      mode = 2'b01; until_val(1'b1, n);
      check(n >= 1 && n <= WIN, "R8 first strobe after switch sets flag", n, WIN);
    end

    // R6 isolated edges
    tx_en = 0; sm_en = 0;
    for (int k = 0; k < 3; k++) begin
      mode = 2'b00; cyc(3 * WIN + k * 3);
      check(los == 1'b1, "R6 idle flag set", los, 1);
      tx_kick = 2; watch(4 * WIN, lows, ch);
      check(lows == WIN, "R6 single tx edge clears one window", lows, WIN);
    end
    mode = 2'b00; cyc(3 * WIN);
    sm_kick = 2; watch(4 * WIN, lows, ch);
    check(lows == 0, "R4 smooth edge ignored in mode 00", lows, 0);
    mode = 2'b01; cyc(3 * WIN);
    sm_kick = 2; watch(4 * WIN, lows, ch);
    check(lows == WIN, "R6 single smooth edge in mode 01", lows, WIN);
    tx_kick = 2; watch(4 * WIN, lows, ch);
    check(lows == 0, "R4 tx edge ignored in mode 01", lows, 0);

    finish_run();
  end
endmodule